// File: doc/BRIEF.md
# Intermittent Bus Fault Injector

This block sits inline on a data bus and flips chosen bits in bursts, so that detection and recovery logic further along the path can be exercised with repeatable intermittent faults. Software or a test harness raises an enable, and the block first waits a programmed number of cycles. It then opens a fault window of a programmed length at the start of every period. This repeats until a programmed injection budget runs out. After that the bus passes through cleanly until the enable is dropped and raised again.

At the first cycle of every fault window a fresh flip mask is drawn and held for the whole window. The mask has either two, three or four bits at distinct pseudo-random positions, or bits placed in adjacent groups: one pair, one run of four, or two pairs that do not overlap. A free-running 16-bit LFSR supplies the positions. The block also reports whether a window is open and how many windows have been opened in the current session.

Top module: `bus_fault_inject`

## Requirements
- R1: After the enable is first seen high at a clock edge E0, no bit is flipped before edge E0+`fi_delay`. The first run cycle is the cycle after edge E0+`fi_delay`.
- R2: During the run, the cycle n cycles after its first cycle is a fault cycle exactly when (n mod `fi_period`) < `fi_on_time`, and `inj_active` is high in exactly those cycles. This covers periods of 1, 10 and 100 cycles and duty ratios of 25%, 50% and 75%.
- R3: The run lasts exactly `fi_total` cycles. After it, `inj_active` stays low and the bus stays clean while the enable remains high.
- R4: In every cycle where `inj_active` is low, `bus_out` equals `bus_in`.
- R5: When `fi_pattern` is 0, 1 or 2, every fault cycle flips exactly 2, 3 or 4 bits respectively.
- R6: When `fi_pattern` is 3, the flipped bits are one pair of adjacent bits. When it is 4, they are one run of four adjacent bits. When it is 5, they are four bits that split into two adjacent pairs with no shared bit.
- R7: Within one fault window, the flip mask (`bus_out` XOR `bus_in`) is the same in every cycle, whatever `bus_in` does.
- R8: `pulse_count` clears when a session starts, and it rises by one in the cycle after each fault window opens. After the run ends it equals the number of windows opened.
- R9: If the enable is seen low at an edge during the wait or the run, `inj_active` is low from the next cycle on, and no further windows are counted.
- R10: With `fi_total` = 0, no fault cycle occurs and `pulse_count` stays 0.
- R11: `fi_pattern` values 6 and 7 open windows as usual (`inj_active` high, windows counted) but flip no bits.
- R12: While reset is asserted, `inj_active` is low, `pulse_count` is 0 and `bus_out` equals `bus_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fi_en | input | 1 | Session enable (level) |
| fi_delay | input | CNT_W | Cycles to wait before the run |
| fi_period | input | CNT_W | Period of the fault windows, in cycles |
| fi_on_time | input | CNT_W | Fault cycles at the start of each period |
| fi_total | input | CNT_W | Length of the run, in cycles |
| fi_pattern | input | 3 | Mask pattern select (codes in R5, R6, R11) |
| bus_in | input | DATA_W | Clean bus from upstream |
| bus_out | output | DATA_W | Bus with faults applied |
| inj_active | output | 1 | High in fault cycles |
| pulse_count | output | PCNT_W | Windows opened this session |

## Verification
The bench uses the default build: a 16-bit bus, 16-bit timing fields and a 16-bit window counter. With these, a 100-cycle period and a run of a few hundred cycles fit in a short run, and every pattern can place its bits anywhere on the bus. Positions are random, so mask checks look at shape and stability, not exact bits. Timing is predicted cycle by cycle from delay, period, on-time and budget, including a 1-cycle period, a zero budget and an abort in mid-run.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  typedef enum logic [1:0] {FI_IDLE, FI_WAIT, FI_RUN, FI_DONE} fi_state_e;

  localparam logic [2:0] PAT_RAND2  = 3'd0;
  localparam logic [2:0] PAT_RAND3  = 3'd1;
  localparam logic [2:0] PAT_RAND4  = 3'd2;
  localparam logic [2:0] PAT_PAIR   = 3'd3;
  localparam logic [2:0] PAT_QUAD   = 3'd4;
  localparam logic [2:0] PAT_2PAIRS = 3'd5;
endpackage

// File: rtl/fbi_lfsr.sv
module fbi_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] rnd
);
  logic [15:0] lfsr_q, lfsr_n;

  always_comb begin
    lfsr_n = {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_n;
  end

  assign rnd = lfsr_q;
endmodule

// File: rtl/fbi_mask_gen.sv
module fbi_mask_gen
  import fbi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [15:0]       rnd,
  input  logic [2:0]        pattern,
  output logic [DATA_W-1:0] mask
);
  localparam int NPROBE = 4;

  function automatic logic [15:0] rot16(input logic [15:0] v, input int s);
    logic [31:0] dd;
    dd = {v, v} >> (16 - s);
    return dd[15:0];
  endfunction

  function automatic logic [DATA_W-1:0] build(input logic [15:0] r, input logic [2:0] pat);
    logic [DATA_W-1:0] m;
    int nbits, pos, b0, b1;
    m = '0;
    case (pat)
      PAT_RAND2, PAT_RAND3, PAT_RAND4: begin
        nbits = int'(pat) + 2;
        for (int k = 0; k < 4; k++) begin
          if (k < nbits) begin
            pos = int'(rot16(r, 4 * k)) % DATA_W;
            for (int s = 0; s < NPROBE; s++) begin
              if (m[pos]) pos = (pos + 1) % DATA_W;
            end
            m[pos] = 1'b1;
          end
        end
      end
      PAT_PAIR: begin
        b0 = int'(r) % (DATA_W - 1);
        m = DATA_W'(3) << b0;
      end
      PAT_QUAD: begin
        b0 = int'(r) % (DATA_W - 3);
        m = DATA_W'(15) << b0;
      end
      PAT_2PAIRS: begin
        b0 = int'(r) % (DATA_W - 1);
        b1 = int'(rot16(r, 8)) % (DATA_W - 1);
        if ((b1 + 1 >= b0) && (b1 <= b0 + 1))
          b1 = (b0 + 3 <= DATA_W - 1) ? b0 + 2 : b0 - 2;
        m = (DATA_W'(3) << b0) | (DATA_W'(3) << b1);
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  always_comb begin
    mask = build(rnd, pattern);
  end
endmodule

// File: rtl/fbi_timer.sv
module fbi_timer
  import fbi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] on_time,
  input  logic [CNT_W-1:0] total,
  output logic             active,
  output logic             win_start,
  output logic             sess_start
);
  fi_state_e        state_q, state_n;
  logic [CNT_W-1:0] dcnt_q, dcnt_n;
  logic [CNT_W-1:0] phase_q, phase_n;
  logic [CNT_W-1:0] tcnt_q, tcnt_n;
  logic             arm;

  always_comb begin
    state_n = state_q;
    dcnt_n  = dcnt_q;
    phase_n = phase_q;
    tcnt_n  = tcnt_q;
    arm     = 1'b0;
    case (state_q)
      FI_IDLE: begin
        if (en) begin
          if (delay == '0) arm = 1'b1;
          else begin
            state_n = FI_WAIT;
            dcnt_n  = delay - 1'b1;
          end
        end
      end
      FI_WAIT: begin
        if (!en)                state_n = FI_IDLE;
        else if (dcnt_q == '0)  arm = 1'b1;
        else                    dcnt_n = dcnt_q - 1'b1;
      end
      FI_RUN: begin
        if (!en) state_n = FI_IDLE;
        else if (({1'b0, tcnt_q} + 1'b1) == {1'b0, total}) state_n = FI_DONE;
        else begin
          tcnt_n  = tcnt_q + 1'b1;
          phase_n = (({1'b0, phase_q} + 1'b1) >= {1'b0, period}) ? '0 : phase_q + 1'b1;
        end
      end
      default: begin
        if (!en) state_n = FI_IDLE;
      end
    endcase
    if (arm) begin
      state_n = (total == '0) ? FI_DONE : FI_RUN;
      phase_n = '0;
      tcnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FI_IDLE;
      dcnt_q  <= '0;
      phase_q <= '0;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      dcnt_q  <= dcnt_n;
      phase_q <= phase_n;
      tcnt_q  <= tcnt_n;
    end
  end

  assign active     = (state_q == FI_RUN) && (phase_q < on_time);
  assign win_start  = active && (phase_q == '0);
  assign sess_start = (state_q == FI_IDLE) && en;

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FI_RUN && period != '0) |-> (phase_q < period)); // R2
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FI_WAIT && en && dcnt_q != '0) |=> (state_q == FI_WAIT)); // R1
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FI_DONE) |-> !active); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != FI_IDLE && !en) |=> (state_q == FI_IDLE && !active)); // R9
endmodule

// File: rtl/bus_fault_inject.sv
module bus_fault_inject
  import fbi_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          CNT_W     = 16,
  parameter int          PCNT_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fi_en,
  input  logic [CNT_W-1:0]  fi_delay,
  input  logic [CNT_W-1:0]  fi_period,
  input  logic [CNT_W-1:0]  fi_on_time,
  input  logic [CNT_W-1:0]  fi_total,
  input  logic [2:0]        fi_pattern,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              inj_active,
  output logic [PCNT_W-1:0] pulse_count
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [15:0]       rnd;
  logic [DATA_W-1:0] mask_new, mask_q, mask_used;
  logic              win_start, sess_start;
  logic [PCNT_W-1:0] pcnt_q, pcnt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fbi_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rnd   (rnd)
  );

  fbi_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .rnd     (rnd),
    .pattern (fi_pattern),
    .mask    (mask_new)
  );

  fbi_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (fi_en),
    .delay      (fi_delay),
    .period     (fi_period),
    .on_time    (fi_on_time),
    .total      (fi_total),
    .active     (inj_active),
    .win_start  (win_start),
    .sess_start (sess_start)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     mask_q <= '0;
    else if (win_start) mask_q <= mask_new;
  end

  assign mask_used = win_start ? mask_new : mask_q;
  assign bus_out   = inj_active ? (bus_in ^ mask_used) : bus_in;

  always_comb begin
    pcnt_n = pcnt_q;
    if (sess_start)     pcnt_n = '0;
    else if (win_start) pcnt_n = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pcnt_q <= '0;
    else            pcnt_q <= pcnt_n;
  end
  assign pulse_count = pcnt_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inj_active && !win_start && $past(inj_active)) |-> (mask_used == $past(mask_used))); // R7
  AST_RAND_POP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inj_active && fi_pattern <= PAT_RAND4) |-> ($countones(mask_used) == int'(fi_pattern) + 2)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    win_start |=> (pulse_count == $past(pulse_count) + 1'b1)); // R8
  AST_COUNT_STILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!win_start && !sess_start) |=> $stable(pulse_count)); // R8
endmodule

// File: tb/bus_fault_inject_test.sv
module bus_fault_inject_test;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fi_en;
  logic [CW-1:0] fi_delay, fi_period, fi_on_time, fi_total;
  logic [2:0]    fi_pattern;
  logic [DW-1:0] bus_in, bus_out;
  logic          inj_active;
  logic [PW-1:0] pulse_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bus_fault_inject #(.DATA_W(DW), .CNT_W(CW), .PCNT_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .fi_en(fi_en), .fi_delay(fi_delay),
    .fi_period(fi_period), .fi_on_time(fi_on_time), .fi_total(fi_total),
    .fi_pattern(fi_pattern), .bus_in(bus_in), .bus_out(bus_out),
    .inj_active(inj_active), .pulse_count(pulse_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pairs_ok(input logic [DW-1:0] m, input int npairs);
    logic [DW-1:0] r, lsb;
    r = m;
    for (int i = 0; i < npairs; i++) begin
      lsb = r & (~r + 1'b1);
      if (lsb == '0 || (r & (lsb << 1)) == '0) return 1'b0;
      r = r ^ (lsb | (lsb << 1));
    end
    return r == '0;
  endfunction

  function automatic bit shape_ok(input logic [2:0] pat, input logic [DW-1:0] m);
    logic [DW-1:0] lsb;
    lsb = m & (~m + 1'b1);
    case (pat)
      3'd0, 3'd1, 3'd2: return $countones(m) == int'(pat) + 2;
      3'd3: return (m != '0) && (m == (lsb | (lsb << 1))) && (lsb[DW-1] == 1'b0);
      3'd4: return (m != '0) && (m == (lsb * 15)) && ($countones(m) == 4);
      3'd5: return ($countones(m) == 4) && pairs_ok(m, 2);
      default: return m == '0;
    endcase
  endfunction

  // one session: delay d, period p, on-time o, budget t, pattern pat
  task automatic run_session(input int d, input int p, input int o, input int t,
                             input logic [2:0] pat, input string req);
    int exp_cnt = 0;
    int ph;
    bit exp_act, in_run;
    logic [DW-1:0] diff, prev_diff;
    prev_diff = '0;
    @(negedge clk);
    fi_delay = CW'(d); fi_period = CW'(p); fi_on_time = CW'(o);
    fi_total = CW'(t); fi_pattern = pat; fi_en = 1'b1;
    for (int j = 0; j < d + t + 4; j++) begin
      @(negedge clk);
      bus_in = DW'($urandom);
      #1;
      in_run  = (t > 0) && (j >= d) && (j < d + t);
      ph      = in_run ? (j - d) % p : 0;
      exp_act = in_run && (ph < o);
      diff    = bus_out ^ bus_in;
      check(inj_active == exp_act, exp_act ? "R2 active" : (j < d ? "R1 wait quiet" : "R3 after run"),
            inj_active, exp_act);
      if (exp_act) begin
        check(shape_ok(pat, diff), pat >= 3'd6 ? "R11 no flip" : (pat <= 3'd2 ? "R5 bit count" : "R6 cluster"),
              diff, 0);
        if (ph != 0) check(diff == prev_diff, "R7 mask hold", diff, prev_diff);
        if (ph == 0) exp_cnt++;
        prev_diff = diff;
      end else begin
        check(diff == '0, "R4 pass-through", diff, 0);
      end
    end
    check(pulse_count == PW'(exp_cnt), {req, " R8 count"}, pulse_count, exp_cnt);
    fi_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    bus_in = 16'hA5C3;
    #1;
    check(inj_active == 1'b0, "R12 active", inj_active, 0);
    check(pulse_count == '0, "R12 count", pulse_count, 0);
    check(bus_out == bus_in, "R12 pass", bus_out, bus_in);
  endtask

  task automatic t_abort;
    @(negedge clk);
    fi_delay = 1; fi_period = 4; fi_on_time = 2; fi_total = 50;
    fi_pattern = 3'd3; fi_en = 1'b1;
    for (int j = 0; j < 7; j++) @(negedge clk);
    // samples j=1..6 saw windows at j=1 and j=5
    fi_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bus_in = DW'($urandom);
      #1;
      check(inj_active == 1'b0, "R9 abort active", inj_active, 0);
      check(bus_out == bus_in, "R9 abort pass", bus_out, bus_in);
    end
    check(pulse_count == 2, "R9 count frozen", pulse_count, 2);
  endtask

  initial begin
    rst_n = 1'b0; fi_en = 1'b0; fi_delay = '0; fi_period = 1; fi_on_time = 1;
    fi_total = '0; fi_pattern = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_session(3, 4, 1, 12, 3'd0, "R2 25pct");
    run_session(0, 10, 5, 25, 3'd3, "R1 zero delay");
    run_session(5, 1, 1, 6, 3'd2, "R2 period1");
    run_session(2, 100, 75, 210, 3'd5, "R2 period100");
    run_session(4, 8, 6, 30, 3'd1, "R5 three");
    run_session(1, 6, 3, 20, 3'd4, "R6 quad");
    run_session(3, 5, 2, 0, 3'd0, "R10 zero budget");
    run_session(1, 3, 2, 9, 3'd7, "R11 code7");
    run_session(0, 4, 4, 8, 3'd6, "R11 code6");
    t_abort();
    run_session(2, 10, 5, 22, 3'd0, "R9 restart");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule